// File: doc/BRIEF.md
# Indexed Block Register Target on a Two-Wire Management Bus

This block is the target side of an SMBus link that fronts a small control register file. A host reaches the registers with two transfer shapes. The indexed block write is: write address, starting index, byte count, then the data bytes. The indexed block read is: write address and starting index, then a repeated start and the read address. The target then returns a byte count, followed by the data. On a write the count comes from the host. On a read the count comes from a writable count register. An index pointer advances after every data byte.

The line inputs are raw SCL and SDA levels from the pads. They pass through a synchronizer stage, and start and stop conditions are recognized from that synchronized view. The block drives SDA only through an open-drain style pull-low request. Three control bytes are presented as parallel outputs for downstream logic: drive-mode selection, per-output enables and per-output stop selection. Identification bytes are fixed and cannot be written.

Top module: `smb_regslave`

## Requirements
- R1: After reset the mode byte (index 0) is 0x00, the enable byte (index 1) is 0xFF, the stop-select byte (index 2) is 0x00 and the count register (index 6) is 0x07. Bit 7 of the mode byte selects the power-down drive mode and bit 6 the stop drive mode, with 0 = driven.
- R2: The target acknowledges the 8-bit write address 0xDC. It also acknowledges the index byte, the count byte X and each data byte that follows. Data bytes land in indices N, N+1 and so on, in order.
- R3: After a repeated start with the 8-bit read address 0xDD, the target first sends the current count register value. It then sends the bytes from index N upward. It leaves SDA released during every host acknowledge slot.
- R4: Only these bits are writable: bits 7,6,5,3,2,1,0 of index 0; bits 6,5,2,1 of index 1; bits 7,1 of index 2; all of index 6. Every other bit keeps its fixed value: bit 4 of index 0 reads 0, the other bits of index 1 read 1, the other bits of index 2 read 0, and index 3 reads 0x00.
- R5: Index 4 reads 0x11, with revision in bits 7:4 and vendor in bits 3:0. Index 5 reads 0x42. Writes to either have no effect.
- R6: An index of 7 or above reads as 0x00, and data written there is discarded.
- R7: An address byte other than 0xDC or 0xDD is not acknowledged. The target then stays silent and changes nothing until the next start.
- R8: Once a read has returned as many data bytes as the count register holds, further bytes requested by the host read 0xFF, because SDA stays released.
- R9: Data bytes beyond the count X of a write are acknowledged and discarded.
- R10: A NACK from the host ends the read. The target keeps SDA released until the next start.
- R11: The target begins pulling SDA low only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad (wired-AND bus) |
| sda_drive_low | output | 1 | 1 = pull SDA low, 0 = release |
| cfg_mode | output | 8 | Index 0 byte: drive-mode controls |
| cfg_enable | output | 8 | Index 1 byte: per-output enables |
| cfg_stoppable | output | 8 | Index 2 byte: per-output stop selection (1 = stoppable) |

## Verification
The bench builds the block with its default parameters. These are a two-flop synchronizer, addresses 0xDC/0xDD, the seven-entry register map with its write masks, and identification values 0x11 and 0x42. This brings the full default map within reach: the masked and read-only bits, the indices past the end, and the read count boundary where the target turns to 0xFF. A host bit-banger with a quarter-bit period of six clocks gives the synchronizer and edge logic room to settle before each bit is used. A behavioural register model is compared with the parallel outputs on every quiet clock.

// File: rtl/smb_regslave_pkg.sv
package smb_regslave_pkg;
   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned NUM_REGS  = 7;
   localparam int unsigned IDX_MODE    = 0;
   localparam int unsigned IDX_ENABLE  = 1;
   localparam int unsigned IDX_STOPSEL = 2;
   localparam int unsigned IDX_SPARE   = 3;
   localparam int unsigned IDX_IDREV   = 4;
   localparam int unsigned IDX_DEVID   = 5;
   localparam int unsigned IDX_COUNT   = 6;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK
   } eng_state_t;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_INDEX,
      PH_COUNT,
      PH_DATA
   } phase_t;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] pipe;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("smb_line_sync: STAGES must be at least 2");
      end
   endgenerate

   // idle bus level is high, so the pipe resets to ones
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe <= '1;
         prev <= 1'b1;
      end else begin
         pipe <= {pipe[STAGES-2:0], line_i};
         prev <= pipe[STAGES-1];
      end
   end

   assign level_o = pipe[STAGES-1];
   assign rise_o  = pipe[STAGES-1] & ~prev;
   assign fall_o  = ~pipe[STAGES-1] & prev;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
   import smb_regslave_pkg::*;
#(
   parameter logic [BYTE_W-1:0] MODE_RST      = 8'h00,
   parameter logic [BYTE_W-1:0] MODE_WMASK    = 8'hEF,
   parameter logic [BYTE_W-1:0] ENABLE_RST    = 8'hFF,
   parameter logic [BYTE_W-1:0] ENABLE_WMASK  = 8'h66,
   parameter logic [BYTE_W-1:0] STOPSEL_RST   = 8'h00,
   parameter logic [BYTE_W-1:0] STOPSEL_WMASK = 8'h82,
   parameter logic [BYTE_W-1:0] IDREV_VAL     = 8'h11,
   parameter logic [BYTE_W-1:0] DEVID_VAL     = 8'h42,
   parameter logic [BYTE_W-1:0] COUNT_RST     = 8'h07
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_idx,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [BYTE_W-1:0] rd_idx,
   output logic [BYTE_W-1:0] rd_data,
   output logic [BYTE_W-1:0] count_val,
   output logic [BYTE_W-1:0] cfg_mode,
   output logic [BYTE_W-1:0] cfg_enable,
   output logic [BYTE_W-1:0] cfg_stoppable
);
   localparam int unsigned       IW   = $clog2(NUM_REGS);
   localparam logic [BYTE_W-1:0] NREG = BYTE_W'(NUM_REGS);

   function automatic logic [BYTE_W-1:0] rst_of(int unsigned i);
      case (i)
         IDX_MODE:    return MODE_RST;
         IDX_ENABLE:  return ENABLE_RST;
         IDX_STOPSEL: return STOPSEL_RST;
         IDX_IDREV:   return IDREV_VAL;
         IDX_DEVID:   return DEVID_VAL;
         IDX_COUNT:   return COUNT_RST;
         default:     return '0;
      endcase
   endfunction

   function automatic logic [BYTE_W-1:0] wmask_of(int unsigned i);
      case (i)
         IDX_MODE:    return MODE_WMASK;
         IDX_ENABLE:  return ENABLE_WMASK;
         IDX_STOPSEL: return STOPSEL_WMASK;
         IDX_COUNT:   return '1;
         default:     return '0;
      endcase
   endfunction

   logic [NUM_REGS-1:0][BYTE_W-1:0] reg_flat;

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         localparam logic [BYTE_W-1:0] RV = rst_of(g);
         localparam logic [BYTE_W-1:0] WM = wmask_of(g);
         if (WM == '0) begin : g_fixed
            assign reg_flat[g] = RV;
         end else begin : g_rw
            logic [BYTE_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  q <= RV;
               end else if (wr_en && (wr_idx == BYTE_W'(g))) begin
                  q <= (q & ~WM) | (wr_data & WM);
               end
            end
            assign reg_flat[g] = q;
         end
      end
   endgenerate

   assign rd_data       = (rd_idx < NREG) ? reg_flat[rd_idx[IW-1:0]] : '0;
   assign count_val     = reg_flat[IDX_COUNT];
   assign cfg_mode      = reg_flat[IDX_MODE];
   assign cfg_enable    = reg_flat[IDX_ENABLE];
   assign cfg_stoppable = reg_flat[IDX_STOPSEL];

   AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(reg_flat)); // R9
   AST_OUT_OF_RANGE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_idx >= NREG)) |=> $stable(reg_flat)); // R6
endmodule

// File: rtl/smb_engine.sv
module smb_engine
   import smb_regslave_pkg::*;
#(
   parameter logic [BYTE_W-1:0] WR_ADDR = 8'hDC,
   parameter logic [BYTE_W-1:0] RD_ADDR = 8'hDD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_lvl,
   input  logic              sda_rise,
   input  logic              sda_fall,
   input  logic [BYTE_W-1:0] rd_data,
   input  logic [BYTE_W-1:0] count_val,
   output logic              sda_oe,
   output logic              wr_en,
   output logic [BYTE_W-1:0] wr_idx,
   output logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] rd_idx
);
   localparam int unsigned CW   = $clog2(BYTE_W + 1);
   localparam logic [CW-1:0] BITS = CW'(BYTE_W);

   eng_state_t        state;
   phase_t            phase;
   logic [CW-1:0]     bitcnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] index;
   logic [BYTE_W-1:0] wr_left;
   logic [BYTE_W-1:0] rd_left;
   logic              rd_mode;
   logic              host_ack;

   logic              start_evt, stop_evt, addr_ok;
   logic [BYTE_W-1:0] idx_inc, tx_next;

   assign start_evt = sda_fall & scl_lvl;
   assign stop_evt  = sda_rise & scl_lvl;
   assign addr_ok   = (shreg == WR_ADDR) || (shreg == RD_ADDR);
   assign idx_inc   = (index == '1) ? index : index + 1'b1;
   assign tx_next   = (rd_left != '0) ? rd_data : '1;
   assign rd_idx    = index;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         phase    <= PH_ADDR;
         bitcnt   <= '0;
         shreg    <= '0;
         index    <= '0;
         wr_left  <= '0;
         rd_left  <= '0;
         rd_mode  <= 1'b0;
         host_ack <= 1'b0;
         sda_oe   <= 1'b0;
         wr_en    <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
      end else begin
         wr_en <= 1'b0;
         if (stop_evt) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (start_evt) begin
            state  <= ST_RX;
            phase  <= PH_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_RX: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && (bitcnt == BITS)) begin
                     bitcnt <= '0;
                     case (phase)
                        PH_ADDR: begin
                           if (addr_ok) begin
                              rd_mode <= (shreg == RD_ADDR);
                              phase   <= PH_INDEX;
                              sda_oe  <= 1'b1;
                              state   <= ST_RX_ACK;
                           end else begin
                              state <= ST_IDLE;
                           end
                        end
                        PH_INDEX: begin
                           index  <= shreg;
                           phase  <= PH_COUNT;
                           sda_oe <= 1'b1;
                           state  <= ST_RX_ACK;
                        end
                        PH_COUNT: begin
                           wr_left <= shreg;
                           phase   <= PH_DATA;
                           sda_oe  <= 1'b1;
                           state   <= ST_RX_ACK;
                        end
                        default: begin
                           if (wr_left != '0) begin
                              wr_en   <= 1'b1;
                              wr_idx  <= index;
                              wr_data <= shreg;
                              wr_left <= wr_left - 1'b1;
                              index   <= idx_inc;
                           end
                           sda_oe <= 1'b1;
                           state  <= ST_RX_ACK;
                        end
                     endcase
                  end
               end
               ST_RX_ACK: begin
                  if (scl_fall) begin
                     if (rd_mode) begin
                        state   <= ST_TX;
                        shreg   <= count_val;
                        rd_left <= count_val;
                        sda_oe  <= ~count_val[BYTE_W-1];
                        bitcnt  <= 1;
                     end else begin
                        state  <= ST_RX;
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bitcnt == BITS) begin
                        sda_oe <= 1'b0;
                        state  <= ST_TX_ACK;
                     end else begin
                        sda_oe <= ~shreg[BYTE_W-2];
                        shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                        bitcnt <= bitcnt + 1'b1;
                     end
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise) begin
                     host_ack <= ~sda_lvl;
                  end else if (scl_fall) begin
                     if (host_ack) begin
                        shreg  <= tx_next;
                        sda_oe <= ~tx_next[BYTE_W-1];
                        bitcnt <= 1;
                        state  <= ST_TX;
                        if (rd_left != '0) begin
                           rd_left <= rd_left - 1'b1;
                           index   <= idx_inc;
                        end
                     end else begin
                        state  <= ST_IDLE;
                        sda_oe <= 1'b0;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   AST_DRIVE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_lvl); // R11
   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe); // R10
   AST_HOST_ACK_SLOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TX_ACK) |-> !sda_oe); // R3
   AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> (state == ST_RX && bitcnt == '0 && phase == PH_ADDR)); // R2
endmodule

// File: rtl/smb_regslave.sv
module smb_regslave
   import smb_regslave_pkg::*;
#(
   parameter int unsigned       SYNC_STAGES   = 2,
   parameter logic [BYTE_W-1:0] WR_ADDR       = 8'hDC,
   parameter logic [BYTE_W-1:0] RD_ADDR       = 8'hDD,
   parameter logic [BYTE_W-1:0] MODE_RST      = 8'h00,
   parameter logic [BYTE_W-1:0] MODE_WMASK    = 8'hEF,
   parameter logic [BYTE_W-1:0] ENABLE_RST    = 8'hFF,
   parameter logic [BYTE_W-1:0] ENABLE_WMASK  = 8'h66,
   parameter logic [BYTE_W-1:0] STOPSEL_RST   = 8'h00,
   parameter logic [BYTE_W-1:0] STOPSEL_WMASK = 8'h82,
   parameter logic [3:0]        REV_ID        = 4'h1,
   parameter logic [3:0]        VEN_ID        = 4'h1,
   parameter logic [BYTE_W-1:0] DEV_ID        = 8'h42,
   parameter logic [BYTE_W-1:0] COUNT_RST     = 8'h07
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_drive_low,
   output logic [BYTE_W-1:0] cfg_mode,
   output logic [BYTE_W-1:0] cfg_enable,
   output logic [BYTE_W-1:0] cfg_stoppable
);
   localparam logic [BYTE_W-1:0] IDREV_VAL = {REV_ID, VEN_ID};

   generate
      if (WR_ADDR[0] != 1'b0) begin : g_bad_wr_addr
         $error("smb_regslave: WR_ADDR must have bit 0 clear");
      end
      if (RD_ADDR != (WR_ADDR | 8'h01)) begin : g_bad_rd_addr
         $error("smb_regslave: RD_ADDR must equal WR_ADDR with bit 0 set");
      end
   endgenerate

   logic scl_lvl, scl_rise, scl_fall;
   logic sda_lvl, sda_rise, sda_fall;
   logic              wr_en;
   logic [BYTE_W-1:0] wr_idx, wr_data, rd_idx, rd_data, count_val;

   smb_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i),
      .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
   );

   smb_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i),
      .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
   );

   smb_engine #(.WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) u_engine (
      .clk(clk), .rst_n(rst_n),
      .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
      .rd_data(rd_data), .count_val(count_val),
      .sda_oe(sda_drive_low), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx)
   );

   smb_regfile #(
      .MODE_RST(MODE_RST), .MODE_WMASK(MODE_WMASK),
      .ENABLE_RST(ENABLE_RST), .ENABLE_WMASK(ENABLE_WMASK),
      .STOPSEL_RST(STOPSEL_RST), .STOPSEL_WMASK(STOPSEL_WMASK),
      .IDREV_VAL(IDREV_VAL), .DEVID_VAL(DEV_ID), .COUNT_RST(COUNT_RST)
   ) u_regfile (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data), .count_val(count_val),
      .cfg_mode(cfg_mode), .cfg_enable(cfg_enable), .cfg_stoppable(cfg_stoppable)
   );
endmodule

// File: tb/smb_regslave_bench.sv
module smb_regslave_bench;
   localparam int CLK_PERIOD = 10;
   localparam int Q          = 6;
   localparam int WATCHDOG   = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_drv = 1'b1;
   logic host_low = 1'b0;
   logic sda_drive_low;
   logic sda_line;
   logic [7:0] cfg_mode, cfg_enable, cfg_stoppable;

   assign sda_line = !(host_low || sda_drive_low);

   always #(CLK_PERIOD/2) clk = ~clk;

   smb_regslave u_smb_regslave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
      .sda_drive_low(sda_drive_low), .cfg_mode(cfg_mode),
      .cfg_enable(cfg_enable), .cfg_stoppable(cfg_stoppable)
   );

   int   checks = 0;
   int   fails  = 0;
   int   cyc    = 0;
   bit   busy   = 1'b0;
   bit   in_rst = 1'b1;
   bit   done   = 1'b0;
   logic prev_oe = 1'b0;
   logic [7:0] mdl   [0:6];
   logic [7:0] wmask [0:6];
   logic [7:0] wbuf  [0:7];

   task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic check1(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] rd_exp(int i);
      return (i < 7) ? mdl[i] : 8'h00;
   endfunction

   // behavioural model compared on every quiet clock
   always @(negedge clk) begin
      if (!in_rst && !done) begin
         if (!busy) begin
            check8("R2/R4 mode output vs model", cfg_mode, mdl[0]);
            check8("R2/R4 enable output vs model", cfg_enable, mdl[1]);
            check8("R2/R4 stop-select output vs model", cfg_stoppable, mdl[2]);
         end
         if (sda_drive_low && !prev_oe)
            check1("R11 pull-low starts with SCL low", scl_drv, 1'b0);
      end
      prev_oe = sda_drive_low;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == WATCHDOG && !done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%0d cycles expected<%0d", cyc, WATCHDOG);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      host_low = 1'b1; tick(Q);
      scl_drv  = 1'b0; tick(Q);
   endtask

   task automatic bus_rstart();
      host_low = 1'b0; tick(Q);
      scl_drv  = 1'b1; tick(Q);
      host_low = 1'b1; tick(Q);
      scl_drv  = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      host_low = 1'b1; tick(Q);
      scl_drv  = 1'b1; tick(Q);
      host_low = 1'b0; tick(2*Q);
   endtask

   // sets busy; caller clears it once the model is current
   task automatic put_byte(logic [7:0] b, logic exp_ack, string tag);
      logic acked;
      busy = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         host_low = !b[i]; tick(Q);
         scl_drv = 1'b1;   tick(2*Q);
         scl_drv = 1'b0;   tick(Q);
      end
      host_low = 1'b0; tick(Q);
      scl_drv = 1'b1;  tick(Q);
      acked = !sda_line; tick(Q);
      scl_drv = 1'b0;  tick(Q);
      check1(tag, acked, exp_ack);
   endtask

   task automatic get_byte(output logic [7:0] b, input logic ack);
      for (int i = 7; i >= 0; i--) begin
         host_low = 1'b0; tick(Q);
         scl_drv = 1'b1;  tick(Q);
         b[i] = sda_line; tick(Q);
         scl_drv = 1'b0;  tick(Q);
      end
      host_low = ack; tick(Q);
      scl_drv = 1'b1; tick(2*Q);
      scl_drv = 1'b0; tick(Q);
      host_low = 1'b0;
   endtask

   task automatic blk_write(int idx, int cnt, int nsend, string tag);
      bus_start();
      put_byte(8'hDC, 1'b1, "R2 write address ack"); busy = 1'b0;
      put_byte(8'(idx), 1'b1, "R2 index ack");       busy = 1'b0;
      put_byte(8'(cnt), 1'b1, "R2 count ack");       busy = 1'b0;
      for (int k = 0; k < nsend; k++) begin
         put_byte(wbuf[k], 1'b1, {tag, " data ack"});
         if (k < cnt && idx + k < 7)
            mdl[idx+k] = (mdl[idx+k] & ~wmask[idx+k]) | (wbuf[k] & wmask[idx+k]);
         busy = 1'b0;
      end
      bus_stop();
   endtask

   task automatic blk_read(int idx, int take, string tag);
      logic [7:0] b;
      logic [7:0] exp;
      logic       seen;
      bus_start();
      put_byte(8'hDC, 1'b1, "R3 write address ack"); busy = 1'b0;
      put_byte(8'(idx), 1'b1, "R3 index ack");       busy = 1'b0;
      bus_rstart();
      put_byte(8'hDD, 1'b1, "R3 read address ack");  busy = 1'b0;
      get_byte(b, 1'b1);
      check8({tag, " R3 count byte"}, b, mdl[6]);
      for (int k = 0; k < take; k++) begin
         get_byte(b, (k < take - 1));
         exp = (k < int'(mdl[6])) ? rd_exp(idx + k) : 8'hFF;
         check8($sformatf("%s byte %0d", tag, k), b, exp);
      end
      seen = 1'b0;
      for (int t = 0; t < 4*Q; t++) begin
         tick(1);
         if (sda_drive_low) seen = 1'b1;
      end
      check1({tag, " R10 released after NACK"}, seen, 1'b0);
      bus_stop();
   endtask

   initial begin
      mdl[0] = 8'h00; mdl[1] = 8'hFF; mdl[2] = 8'h00; mdl[3] = 8'h00;
      mdl[4] = 8'h11; mdl[5] = 8'h42; mdl[6] = 8'h07;
      wmask[0] = 8'hEF; wmask[1] = 8'h66; wmask[2] = 8'h82; wmask[3] = 8'h00;
      wmask[4] = 8'h00; wmask[5] = 8'h00; wmask[6] = 8'hFF;
      tick(5);
      rst_n = 1'b1;
      tick(1);
      in_rst = 1'b0;
      tick(4);

      check8("R1 reset mode byte", cfg_mode, 8'h00);
      check8("R1 reset enable byte", cfg_enable, 8'hFF);
      check8("R1 reset stop-select byte", cfg_stoppable, 8'h00);
      check1("R1 SDA released after reset", sda_drive_low, 1'b0);

      // R1 R3 R5: full read at reset, count 7
      blk_read(0, 7, "R5 reset map read");

      // R4: all ones then all zeros into the control bytes
      wbuf[0] = 8'hFF; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF;
      blk_write(0, 3, 3, "R4 ones");
      check8("R4 mode after ones", cfg_mode, 8'hEF);
      check8("R4 enable after ones", cfg_enable, 8'hFF);
      check8("R4 stop-select after ones", cfg_stoppable, 8'h82);
      wbuf[0] = 8'h00; wbuf[1] = 8'h00; wbuf[2] = 8'h00;
      blk_write(0, 3, 3, "R4 zeros");
      check8("R4 enable after zeros", cfg_enable, 8'h99);

      // R5: writes to fixed and identification bytes ignored
      wbuf[0] = 8'hAA; wbuf[1] = 8'h55; wbuf[2] = 8'h13;
      blk_write(3, 3, 3, "R5 id write");
      blk_read(3, 7, "R6 read across end");

      // R8: count shrunk to 2, host asks for 4
      wbuf[0] = 8'h02;
      blk_write(6, 1, 1, "R3 count write");
      blk_read(0, 4, "R8 past count");

      // R6: writes past the end dropped
      wbuf[0] = 8'h11; wbuf[1] = 8'h22;
      blk_write(7, 2, 2, "R6 out of range");
      blk_read(7, 2, "R6 out of range read");

      // R9: surplus data beyond the count
      wbuf[0] = 8'hFF; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF;
      blk_write(1, 1, 3, "R9 surplus");
      check8("R9 enable written", cfg_enable, 8'hFF);
      check8("R9 stop-select untouched", cfg_stoppable, 8'h00);

      // R7: foreign address
      bus_start();
      put_byte(8'hA0, 1'b0, "R7 foreign address not acked"); busy = 1'b0;
      put_byte(8'h00, 1'b0, "R7 silent after foreign address"); busy = 1'b0;
      bus_stop();
      check8("R7 mode unchanged", cfg_mode, mdl[0]);

      // R3: restore count and read mixed pattern
      wbuf[0] = 8'hA5; wbuf[1] = 8'h07;
      blk_write(5, 2, 2, "R3 restore count");
      wbuf[0] = 8'h81; wbuf[1] = 8'h24; wbuf[2] = 8'h02;
      blk_write(0, 3, 3, "R2 pattern");
      blk_read(1, 7, "R3 offset read");

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule